// File: doc/BRIEF.md
# Accumulator Processor Core

A small multicycle processor for control tasks that need very little logic. It holds an 8-bit accumulator, one 8-bit helper register and a single zero flag. It runs programs from a byte-wide memory of 64K locations through a synchronous port. Peripherals sit in that same address space, so ordinary loads and stores reach them.

Each instruction begins with a one-byte opcode. Loads, stores and jumps carry a 16-bit address in the next two bytes, low byte first. The core works through fetch, decode, address and memory steps one clock at a time. It never reads and writes memory in the same cycle. A halt opcode parks the core, stops all memory traffic and raises a status output.

Top module: `acc_cpu`

## Requirements
- R1: A high `rst` clears the program counter, accumulator, helper register and zero flag. While `rst` is high and in the first cycle after it, the core requests a read at address 0.
- R2: Cycle counts are fixed: 2 for an opcode with no address, 4 for a store or jump, and 5 for a load. The halt opcode raises `halted` 2 cycles after its fetch. Address bytes are read low byte first.
- R3: LDAC (0x01) copies the byte at its 16-bit address into the accumulator and leaves the zero flag unchanged.
- R4: STAC (0x02) writes the accumulator to its 16-bit address and leaves the accumulator and the zero flag unchanged.
- R5: MVAC (0x03) copies the accumulator into the helper register. MOVR (0x04) copies the helper register into the accumulator. Neither one changes the zero flag.
- R6: The arithmetic opcodes work modulo 256: ADD (0x08) adds the helper register, SUB (0x09) subtracts it, INAC (0x0A) adds one and CLAC (0x0B) loads zero. Each sets the zero flag to 1 exactly when its result is zero.
- R7: The logic opcodes are AND (0x0C), OR (0x0D) and XOR (0x0E) with the helper register, and NOT (0x0F), which inverts the accumulator. Each sets the zero flag from its result.
- R8: JUMP (0x05) always continues at its 16-bit target.
- R9: JMPZ (0x06) branches only when the zero flag is 1, and JPNZ (0x07) branches only when it is 0. When the branch is not taken, execution continues at the byte after the address field.
- R10: Opcode 0xFF halts the core. Once halted, `halted` stays high and no further read or write is issued. Opcode 0x00 and every opcode from 0x10 to 0xFE except 0xFF is a no-operation.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Read request. Data returns on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data from the previous read request |
| halted | output | 1 | High once a halt opcode has executed |

## Verification
Each result is due a fixed number of cycles after its opcode is fetched. That is 2 cycles for register and logic operations, 4 for stores and jumps, and 5 for loads. A program's total run time to `halted` therefore follows from the path it takes. The bench counts rising edges from the release of reset and samples one time unit after each edge. It compares that count with the total computed for the program, then reads the stored results and flag markers out of its memory model once the core halts. The sweep covers every data opcode, two unused opcodes and a grid of operand values, including 0x00, 0x80 and 0xFF, where wraparound and the zero flag matter.

// File: rtl/acc_cpu.sv
module acc_cpu (
  input  logic        clk,
  input  logic        rst,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        halted
);
  localparam logic [7:0] OP_LDAC = 8'h01, OP_STAC = 8'h02, OP_MVAC = 8'h03,
                         OP_MOVR = 8'h04, OP_JUMP = 8'h05, OP_JMPZ = 8'h06,
                         OP_JPNZ = 8'h07, OP_ADD  = 8'h08, OP_SUB  = 8'h09,
                         OP_INAC = 8'h0A, OP_CLAC = 8'h0B, OP_AND  = 8'h0C,
                         OP_OR   = 8'h0D, OP_XOR  = 8'h0E, OP_NOT  = 8'h0F,
                         OP_HALT = 8'hFF;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_LO, S_HI, S_LD, S_HALT} state_t;

  state_t      state;
  logic [15:0] pc;
  logic [7:0]  ac, r, ir, lo;
  logic        z;

  logic        has_addr, ac_we, z_we;
  logic [7:0]  alu_res;
  logic [15:0] target;

  assign has_addr = (mem_rdata >= OP_LDAC && mem_rdata <= OP_STAC) ||
                    (mem_rdata >= OP_JUMP && mem_rdata <= OP_JPNZ);
  assign target   = {mem_rdata, lo};

  assign mem_rd    = (state == S_FETCH) || (state == S_LO) ||
                     (state == S_DEC && has_addr) ||
                     (state == S_HI && ir == OP_LDAC);
  assign mem_wr    = (state == S_HI) && (ir == OP_STAC);
  assign mem_addr  = (state == S_HI) ? target : pc;
  assign mem_wdata = ac;
  assign halted    = (state == S_HALT);

  always_comb begin
    alu_res = ac;
    ac_we   = 1'b1;
    z_we    = 1'b1;
    case (mem_rdata)
      OP_ADD:  alu_res = ac + r;
      OP_SUB:  alu_res = ac - r;
      OP_INAC: alu_res = ac + 8'd1;
      OP_CLAC: alu_res = 8'd0;
      OP_AND:  alu_res = ac & r;
      OP_OR:   alu_res = ac | r;
      OP_XOR:  alu_res = ac ^ r;
      OP_NOT:  alu_res = ~ac;
      OP_MOVR: begin alu_res = r; z_we = 1'b0; end
      default: begin ac_we = 1'b0; z_we = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= 16'd0;
      ac    <= 8'd0;
      r     <= 8'd0;
      z     <= 1'b0;
      ir    <= 8'd0;
      lo    <= 8'd0;
    end else begin
      case (state)
        S_FETCH: begin
          pc    <= pc + 16'd1;
          state <= S_DEC;
        end
        S_DEC: begin
          ir <= mem_rdata;
          if (has_addr) begin
            pc    <= pc + 16'd1;
            state <= S_LO;
          end else if (mem_rdata == OP_HALT) begin
            state <= S_HALT;
          end else begin
            if (ac_we) ac <= alu_res;
            if (z_we)  z  <= (alu_res == 8'd0);
            if (mem_rdata == OP_MVAC) r <= ac;
            state <= S_FETCH;
          end
        end
        S_LO: begin
          lo    <= mem_rdata;
          pc    <= pc + 16'd1;
          state <= S_HI;
        end
        S_HI: begin
          state <= (ir == OP_LDAC) ? S_LD : S_FETCH;
          if (ir == OP_JUMP || (ir == OP_JMPZ && z) || (ir == OP_JPNZ && !z))
            pc <= target;
        end
        S_LD: begin
          ac    <= mem_rdata;
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && !mem_rd && !mem_wr);

  p_load_keeps_z_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_LD) |=> $stable(z) && ac == $past(mem_rdata));

  p_store_keeps_state_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> $stable(z) && $stable(ac));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && z_we && !has_addr) |=> z == (ac == 8'd0));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_LO) |=> pc == $past(pc) + 16'd1);
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'd0;
  logic [7:0]  mem [0:511];

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  endtask

  task automatic put3(input int at, input logic [7:0] op, input logic [15:0] a);
    mem[at] = op; mem[at+1] = a[7:0]; mem[at+2] = a[15:8];
  endtask

  task automatic hold_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    @(negedge clk) rst = 1'b0;
    while (!halted && cyc < 20000) begin
      @(posedge clk);
      cyc++;
      #1;
    end
  endtask

  function automatic logic [8:0] model(input logic [7:0] op, input logic [7:0] a,
                                       input logic [7:0] b);
    logic [7:0] res;
    logic zu;
    zu = 1'b1;
    case (op)
      8'h08: res = a + b;
      8'h09: res = a - b;
      8'h0A: res = a + 8'd1;
      8'h0B: res = 8'd0;
      8'h0C: res = a & b;
      8'h0D: res = a | b;
      8'h0E: res = a ^ b;
      8'h0F: res = ~a;
      8'h04: begin res = b; zu = 1'b0; end
      default: begin res = a; zu = 1'b0; end
    endcase
    return {zu && (res == 8'd0), res};
  endfunction

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops [12];
    logic [7:0] vals [8];
    logic [8:0] exp;
    int cyc;
    ops  = '{8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F,
             8'h04, 8'h03, 8'h00, 8'h42};
    vals = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h0F, 8'hF0, 8'h55};

    // R1: outputs while reset is held
    clear_mem();
    hold_reset();
    #1;
    chk(mem_rd === 1'b1 && mem_addr === 16'd0, "R1 first read at 0", mem_addr, 0);
    chk(mem_wr === 1'b0 && halted === 1'b0, "R1 idle in reset", {mem_wr, halted}, 0);

    // R3 R5 R6 R7 R9 R10 R2: sweep of data opcodes
    foreach (ops[k]) begin
      foreach (vals[i]) begin
        foreach (vals[j]) begin
          clear_mem();
          put3(0, 8'h01, 16'h0100);
          mem[3] = 8'h03;
          put3(4, 8'h01, 16'h0101);
          mem[7] = ops[k];
          put3(8, 8'h02, 16'h0102);
          put3(11, 8'h06, 16'h0020);
          mem[14] = 8'h0B;
          put3(15, 8'h02, 16'h0103);
          mem[18] = 8'hFF;
          mem[32] = 8'h0B;
          mem[33] = 8'h0A;
          put3(34, 8'h02, 16'h0103);
          mem[37] = 8'hFF;
          mem[256] = vals[j];
          mem[257] = vals[i];
          hold_reset();
          run(cyc);
          exp = model(ops[k], vals[i], vals[j]);
          chk(mem[258] === exp[7:0], $sformatf("R6 R7 R5 result op %0h", ops[k]),
              mem[258], exp[7:0]);
          chk(mem[259] === {7'd0, exp[8]}, $sformatf("R3 R6 R9 zero flag op %0h", ops[k]),
              mem[259], exp[8]);
          chk(cyc == (exp[8] ? 32 : 30), "R2 cycle count", cyc, exp[8] ? 32 : 30);
        end
      end
    end

    // R1: registers cleared after a run that left them nonzero
    clear_mem();
    put3(0, 8'h02, 16'h0104);
    mem[3] = 8'h04;
    put3(4, 8'h02, 16'h0105);
    put3(7, 8'h07, 16'h0010);
    mem[10] = 8'hFF;
    mem[16] = 8'h0B;
    mem[17] = 8'h0A;
    put3(18, 8'h02, 16'h0106);
    mem[21] = 8'hFF;
    mem[260] = 8'hAA; mem[261] = 8'hAA; mem[262] = 8'hAA;
    hold_reset();
    run(cyc);
    chk(mem[260] === 8'd0, "R1 accumulator cleared", mem[260], 0);
    chk(mem[261] === 8'd0, "R1 helper register cleared", mem[261], 0);
    chk(mem[262] === 8'd1, "R1 R9 zero flag cleared, JPNZ taken", mem[262], 1);

    // R8: unconditional jump skips the store
    clear_mem();
    put3(0, 8'h05, 16'h0010);
    mem[3] = 8'h0B;
    put3(4, 8'h02, 16'h0103);
    mem[7] = 8'hFF;
    mem[16] = 8'hFF;
    mem[259] = 8'h55;
    hold_reset();
    run(cyc);
    chk(mem[259] === 8'h55, "R8 jump target", mem[259], 8'h55);
    chk(cyc == 6, "R8 R2 jump timing", cyc, 6);

    // R10: halted core stays quiet
    for (int t = 0; t < 10; t++) begin
      @(posedge clk); #1;
      chk(halted === 1'b1 && mem_rd === 1'b0 && mem_wr === 1'b0, "R10 halt hold",
          {halted, mem_rd, mem_wr}, 4);
    end

    // R9 R4: countdown loop on JPNZ, flag kept across the store
    foreach (vals[n]) begin
      if (n > 4) break;
      clear_mem();
      mem[0] = 8'h0B; mem[1] = 8'h0A; mem[2] = 8'h03;
      put3(3, 8'h01, 16'h0102);
      mem[6] = 8'h0A;
      put3(7, 8'h02, 16'h0102);
      put3(10, 8'h01, 16'h0101);
      mem[13] = 8'h09;
      put3(14, 8'h02, 16'h0101);
      put3(17, 8'h07, 16'h0003);
      mem[20] = 8'hFF;
      mem[257] = (n == 4) ? 8'd0 : 8'(n + 1);
      hold_reset();
      run(cyc);
      chk(mem[258] === ((n == 4) ? 8'd0 : 8'(n + 1)), "R9 loop iterations",
          mem[258], (n == 4) ? 0 : n + 1);
      chk(mem[257] === 8'd0, "R4 R9 countdown end", mem[257], 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule